// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a field-configurable two-level logic plane. A set of input signals is buffered into true and complemented literals. A configuration map selects which literals take part in each product term (AND). The product terms are split into fixed groups, and each group is ORed into one sum per output. The sums go on to downstream output cells. The logic path from `sig_in` to `sum_out` is purely combinational. The only clocked logic is the serial interface that loads the configuration map.

Software loads the map one bit per clock. It holds `cfg_shift` high and presents `cfg_bit` on each cycle. Once the last bit is in, `load_done` rises and the sums become live. A one-cycle `cfg_clear` pulse makes the block ready for a fresh load. With the default parameters there are 20 signals, 40 literal columns, 64 product terms and 8 outputs. Each output takes 8 terms, so the map holds 2560 bits.

Top module: `sop_array`

## Requirements
- R1: While reset is active, and in the first cycle after it, `load_done` is 0 and `sum_out` is all zeros.
- R2: Each clock edge with `cfg_shift` high and `load_done` low takes in one map bit. The first bit taken becomes map index 0. Index `t*40+c` is product term t, column c. Column 2s is the true literal of `sig_in[s]` and column 2s+1 is its complement. A map bit of 1 connects that literal to the term.
- R3: `load_done` rises on the clock edge that takes in the 2560th bit. While `load_done` is 0, `sum_out` is all zeros.
- R4: A product term with no connected literal evaluates to 1.
- R5: A product term connected to both the true and the complemented literal of one signal evaluates to 0, whatever the inputs are.
- R6: Once loaded, `sum_out[k]` is the OR of product terms 8k to 8k+7.
- R7: While `load_done` is 1, `cfg_shift` has no effect. The map, `load_done` and `sum_out` all stay unchanged.
- R8: A `cfg_clear` pulse clears `load_done` and restarts the bit count on the next edge. It takes priority over `cfg_shift`.
- R9: After loading, `sum_out` follows a change of `sig_in` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration interface |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clear | input | 1 | Restart pulse: drops `load_done` and zeroes the bit count |
| cfg_shift | input | 1 | Load enable: take in `cfg_bit` on this edge |
| cfg_bit | input | 1 | Serial map bit |
| sig_in | input | 20 | Logic input signals |
| load_done | output | 1 | Map complete; sums are valid |
| sum_out | output | 8 | One sum of products per output |

## Verification
Two things can fall in the same cycle. A configuration request (`cfg_shift` or `cfg_clear`) can arrive while the array is live and evaluating `sig_in`. Two cases provoke this. In the first, extra bits are shifted after `load_done`, and the bench then checks that the sums for known input vectors still match the loaded map. In the second, `cfg_clear` is pulsed while the array is live, and the bench checks that the outputs fall to zero on the next edge. A reference evaluation in the bench computes the expected sums for directed maps and for a random sparse map, and the comparison is made at the ports after each input change.

// File: rtl/sop_pkg.sv
package sop_pkg;
    localparam int unsigned SIGS_DEF     = 20;
    localparam int unsigned OUTS_DEF     = 8;
    localparam int unsigned TERMS_PER_DEF = 8;

    // Column index of a literal: true form at even, complement at odd.
    function automatic int unsigned lit_col(input int unsigned sig, input logic inv);
        return 2 * sig + (inv ? 1 : 0);
    endfunction
endpackage

// File: rtl/sop_cfg_loader.sv
module sop_cfg_loader #(
    parameter int unsigned MAP_BITS = 2560
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_clear,
    input  logic                cfg_shift,
    input  logic                cfg_bit,
    output logic [MAP_BITS-1:0] fuse_map,
    output logic [$clog2(MAP_BITS+1)-1:0] bit_cnt,
    output logic                load_done
);
    localparam int unsigned CNT_W = $clog2(MAP_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAP_BITS - 1);

    typedef struct packed {
        logic [MAP_BITS-1:0] fuse;
        logic [CNT_W-1:0]    cnt;
        logic                done;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_clear) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else if (cfg_shift && !st_q.done) begin
            // New bit enters at the top; the first bit ends at index 0.
            st_d.fuse = {cfg_bit, st_q.fuse[MAP_BITS-1:1]};
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fuse_map  = st_q.fuse;
    assign bit_cnt   = st_q.cnt;
    assign load_done = st_q.done;
endmodule

// File: rtl/sop_literals.sv
module sop_literals #(
    parameter int unsigned SIGS = 20
) (
    input  logic [SIGS-1:0]   sig,
    output logic [2*SIGS-1:0] lits
);
    for (genvar s = 0; s < SIGS; s++) begin : g_buf
        assign lits[sop_pkg::lit_col(s, 1'b0)] = sig[s];
        assign lits[sop_pkg::lit_col(s, 1'b1)] = ~sig[s];
    end
endmodule

// File: rtl/sop_term.sv
module sop_term #(
    parameter int unsigned COLS = 40
) (
    input  logic [COLS-1:0] lits,
    input  logic [COLS-1:0] conn,
    output logic            term
);
    // Unconnected columns read as 1, so an empty term is HIGH and a term
    // holding both polarities of a signal is LOW.
    assign term = &(~conn | lits);
endmodule

// File: rtl/sop_array.sv
module sop_array #(
    parameter int unsigned SIGS      = sop_pkg::SIGS_DEF,
    parameter int unsigned OUTS      = sop_pkg::OUTS_DEF,
    parameter int unsigned TERMS_PER = sop_pkg::TERMS_PER_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_clear,
    input  logic            cfg_shift,
    input  logic            cfg_bit,
    input  logic [SIGS-1:0] sig_in,
    output logic            load_done,
    output logic [OUTS-1:0] sum_out
);
    localparam int unsigned COLS     = 2 * SIGS;
    localparam int unsigned TERMS    = OUTS * TERMS_PER;
    localparam int unsigned MAP_BITS = TERMS * COLS;
    localparam int unsigned CNT_W    = $clog2(MAP_BITS + 1);

    logic [MAP_BITS-1:0] fuse_map;
    logic [CNT_W-1:0]    bit_cnt;
    logic [COLS-1:0]     lits;
    logic [TERMS-1:0]    terms;
    logic [OUTS-1:0]     sums;

    sop_cfg_loader #(.MAP_BITS(MAP_BITS)) i_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_clear (cfg_clear),
        .cfg_shift (cfg_shift),
        .cfg_bit   (cfg_bit),
        .fuse_map  (fuse_map),
        .bit_cnt   (bit_cnt),
        .load_done (load_done)
    );

    sop_literals #(.SIGS(SIGS)) i_lits (
        .sig  (sig_in),
        .lits (lits)
    );

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        sop_term #(.COLS(COLS)) i_term (
            .lits (lits),
            .conn (fuse_map[t*COLS +: COLS]),
            .term (terms[t])
        );
    end

    for (genvar k = 0; k < OUTS; k++) begin : g_sum
        assign sums[k] = |terms[k*TERMS_PER +: TERMS_PER];
    end

    assign sum_out = load_done ? sums : '0;
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
    parameter int unsigned OUTS     = 8,
    parameter int unsigned MAP_BITS = 2560,
    parameter int unsigned CNT_W    = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_clear,
    input logic                cfg_shift,
    input logic                load_done,
    input logic [OUTS-1:0]     sum_out,
    input logic [MAP_BITS-1:0] fuse_map,
    input logic [CNT_W-1:0]    bit_cnt
);
    // R3: sums stay dark until the map is complete
    p_out_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_done |-> sum_out == '0);

    // R3: completion only comes from a shift edge
    p_done_from_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_done) |-> $past(cfg_shift) && !$past(cfg_clear));

    // R8: a clear pulse drops completion
    p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> !load_done && bit_cnt == '0);

    // R7: a loaded map is frozen until cleared
    p_map_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_done && !cfg_clear |=> load_done && $stable(fuse_map));

    // R2: the count never runs past the map size
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(MAP_BITS));
endmodule

bind sop_array sop_array_chk #(
    .OUTS(OUTS), .MAP_BITS(MAP_BITS), .CNT_W(CNT_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_clear (cfg_clear),
    .cfg_shift (cfg_shift),
    .load_done (load_done),
    .sum_out   (sum_out),
    .fuse_map  (fuse_map),
    .bit_cnt   (bit_cnt)
);

// File: tb/test_sop_array.sv
module test_sop_array;
    localparam int SIGS = 20;
    localparam int OUTS = 8;
    localparam int TPER = 8;
    localparam int COLS = 2 * SIGS;
    localparam int TERMS = OUTS * TPER;
    localparam int TOTAL = TERMS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_clear = 1'b0;
    logic cfg_shift = 1'b0;
    logic cfg_bit = 1'b0;
    logic [SIGS-1:0] sig_in = '0;
    logic load_done;
    logic [OUTS-1:0] sum_out;

    int checks = 0;
    int errors = 0;
    bit fmap [TOTAL];

    // Map A: out k = sig[k] for k<7, out7 = sig7 | ~sig19. Entries {sig_in, expected}.
    localparam logic [27:0] VEC [6] = '{
        {20'h00000, 8'h80},
        {20'h80000, 8'h00},
        {20'hFFFFF, 8'hFF},
        {20'h800AA, 8'hAA},
        {20'h80055, 8'h55},
        {20'h7FF00, 8'h80}
    };

    always #5 clk = ~clk;

    sop_array i_sop_array (
        .clk(clk), .rst_n(rst_n), .cfg_clear(cfg_clear), .cfg_shift(cfg_shift),
        .cfg_bit(cfg_bit), .sig_in(sig_in), .load_done(load_done), .sum_out(sum_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [OUTS-1:0] model(input logic [SIGS-1:0] s);
        logic [OUTS-1:0] r = '0;
        for (int t = 0; t < TERMS; t++) begin
            logic p = 1'b1;
            for (int c = 0; c < COLS; c++) begin
                logic lit = (c % 2 == 0) ? s[c/2] : ~s[c/2];
                if (fmap[t*COLS + c] && !lit) p = 1'b0;
            end
            if (p) r[t / TPER] = 1'b1;
        end
        return r;
    endfunction

    task automatic load_map();
        for (int i = 0; i < TOTAL; i++) begin
            @(negedge clk);
            if (i == TOTAL / 2) begin
                check("R3 mid-load done", 32'(load_done), 0);
                check("R3 mid-load gated", 32'(sum_out), 0);
            end
            if (i == TOTAL - 1) check("R3 done before last bit", 32'(load_done), 0);
            cfg_shift = 1'b1;
            cfg_bit = fmap[i];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        check("R3 done after last bit", 32'(load_done), 1);
    endtask

    task automatic clear_pulse();
        @(negedge clk);
        cfg_clear = 1'b1;
        @(negedge clk);
        cfg_clear = 1'b0;
    endtask

    task automatic run_table(input string req);
        for (int v = 0; v < 6; v++) begin
            sig_in = VEC[v][27:8];
            #1;
            check(req, 32'(sum_out), 32'(VEC[v][7:0]));
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        #12;
        check("R1 done in reset", 32'(load_done), 0);
        check("R1 sums in reset", 32'(sum_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after reset", 32'(load_done), 0);
        check("R1 sums after reset", 32'(sum_out), 0);

        // Map A: directed (R2 ordering, R5 killed terms, R6 grouping)
        foreach (fmap[i]) fmap[i] = 1'b0;
        for (int k = 0; k < OUTS; k++) begin
            fmap[(k*TPER)*COLS + 2*k] = 1'b1;
            for (int j = 1; j < TPER; j++) begin
                fmap[(k*TPER + j)*COLS + 0] = 1'b1;
                fmap[(k*TPER + j)*COLS + 1] = 1'b1;
            end
        end
        fmap[57*COLS + 0] = 1'b0;
        fmap[57*COLS + 1] = 1'b0;
        fmap[57*COLS + 39] = 1'b1;
        load_map();
        run_table("R2/R5/R6 map A table");

        // R9: combinational follow without a clock edge
        @(posedge clk);
        #2;
        sig_in = 20'h80001;
        #1;
        check("R9 comb follow", 32'(sum_out), 32'h01);

        // R7: extra shifts while done are ignored
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_bit = ~cfg_bit;
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        check("R7 done held", 32'(load_done), 1);
        run_table("R7 map A after extra shifts");

        // R8: clear has priority over a simultaneous shift
        @(negedge clk);
        cfg_clear = 1'b1;
        cfg_shift = 1'b1;
        sig_in = 20'hFFFFF;
        @(negedge clk);
        cfg_clear = 1'b0;
        cfg_shift = 1'b0;
        check("R8 done cleared", 32'(load_done), 0);
        check("R8 sums gated", 32'(sum_out), 0);

        // R4: empty map -> every term HIGH
        foreach (fmap[i]) fmap[i] = 1'b0;
        load_map();
        sig_in = 20'h12345;
        #1;
        check("R4 empty terms", 32'(sum_out), 32'hFF);
        sig_in = 20'h00000;
        #1;
        check("R4 empty terms zero input", 32'(sum_out), 32'hFF);

        // R5: all literals connected -> every term LOW
        clear_pulse();
        foreach (fmap[i]) fmap[i] = 1'b1;
        load_map();
        sig_in = 20'hFFFFF;
        #1;
        check("R5 both polarities", 32'(sum_out), 32'h00);

        // R6/R2: random sparse map against reference evaluation
        clear_pulse();
        for (int t = 0; t < TERMS; t++) begin
            bit empty = ($urandom % 5 == 0);
            for (int c = 0; c < COLS; c++)
                fmap[t*COLS + c] = !empty && ($urandom % 14 == 0);
        end
        load_map();
        for (int n = 0; n < 60; n++) begin
            sig_in = SIGS'($urandom);
            #1;
            check("R6 random map vs model", 32'(sum_out), 32'(model(sig_in)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule